// File: doc/BRIEF.md
# Secure/Non-Secure Mirrored Address Decoder

This block is the address decoder of a small subsystem fabric. It is purely combinational: for every address presented with a valid strobe, it raises one target-select line and produces the byte offset inside the selected target. It also drives a miss flag.

Several 256 MB windows are mirrors of lower windows. The 0x1 window mirrors 0x0, the 0x3 window mirrors 0x2, and the 0x5 window mirrors 0x4. As a result, one device answers at a secure and at a non-secure address.

A handful of control devices live only in the 0x5 window and win over the mirror there. Explicit devices in the folded address space come next. Any address that nothing claims goes to an external expansion port at the lowest priority.

Top module: `sna_alias_decoder`

## Requirements
- R1: `sel_o` is a 14-bit one-hot vector whenever `valid_i` is high. Its bit positions are: 0 RAM, 1 timer A, 2 timer B, 3 timer C, 4 slow timer, 5 secure controller port, 6 non-secure controller port, 7 system control, 8 slow watchdog, 9 secure watchdog, 10 RAM guard port, 11 non-secure watchdog, 12 system info, 13 expansion.
- R2: With `valid_i` low, `sel_o` is all zero, `offset_o` is zero and `miss_o` is high. With `valid_i` high, `miss_o` is low.
- R3: An address in 0x1000_0000..0x1FFF_FFFF decodes exactly as the same address with bit 28 cleared.
- R4: An address in 0x3000_0000..0x3FFF_FFFF decodes as the same address with bit 28 cleared. For example, 0x3000_0010 selects the RAM at offset 0x10.
- R5: An address in the 0x5 window that hits no secure-only device decodes as the same address with bit 28 cleared. This covers, for example, the timers, the system info block and the slow timer.
- R6: 0x2000_0000..0x2000_7FFF (32 KB) selects the RAM, and the offset is the low 15 bits. 0x2000_8000 does not select the RAM.
- R7: The 4 KB slots 0x4000_0000, 0x4000_1000 and 0x4000_2000 select timers A, B and C. The slot 0x4002_F000 selects the slow timer. The offset is the low 12 bits.
- R8: 0x4008_0000 selects the non-secure controller port, and 0x5008_0000 selects the secure controller port (4 KB each).
- R9: The secure-only slots override the mirror: 0x5002_1000 system control, 0x5002_E000 slow watchdog, 0x5008_1000 secure watchdog, 0x5008_3000 RAM guard port. The matching 0x4 addresses do not reach them. 0x4008_1000 is the non-secure watchdog and 0x4002_0000 is the system info block.
- R10: Any valid address that claims no device selects the expansion port, with an offset equal to the address after mirror folding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 32 | Byte address to decode |
| valid_i | input | 1 | Address qualifier |
| sel_o | output | 14 | One-hot target select |
| offset_o | output | 32 | Offset within the selected target |
| miss_o | output | 1 | No target reached |

## Verification
Immediate assertions check on every evaluation that:
- the select is one-hot whenever the strobe is high;
- the miss flag mirrors the strobe;
- the fold never leaves an address inside a mirror window;
- an offset never exceeds the span of its target;
- a secure-only target is reached only from the 0x5 window.

The correct target for a given address, the folding of each window, and the priority of secure-only slots over the mirror show only in the bench sweep. That sweep crosses all sixteen windows with boundary offsets and compares the results against an arithmetic model.

// File: rtl/sna_dec_pkg.sv
package sna_dec_pkg;

   localparam int NUM_TGT  = 14;
   localparam int EXP_IDX  = NUM_TGT - 1;

   typedef enum int unsigned {
      T_RAM      = 0,
      T_TMR_A    = 1,
      T_TMR_B    = 2,
      T_TMR_C    = 3,
      T_TMR_SLOW = 4,
      T_CTL_SEC  = 5,
      T_CTL_NS   = 6,
      T_SYSCTL   = 7,
      T_WDG_SLOW = 8,
      T_WDG_SEC  = 9,
      T_RAMGUARD = 10,
      T_WDG_NS   = 11,
      T_SYSINFO  = 12,
      T_EXPAN    = 13
   } tgt_e;

   function automatic logic [31:0] tgt_base(int idx);
      case (idx)
         T_RAM:      return 32'h2000_0000;
         T_TMR_A:    return 32'h4000_0000;
         T_TMR_B:    return 32'h4000_1000;
         T_TMR_C:    return 32'h4000_2000;
         T_TMR_SLOW: return 32'h4002_F000;
         T_CTL_SEC:  return 32'h5008_0000;
         T_CTL_NS:   return 32'h4008_0000;
         T_SYSCTL:   return 32'h5002_1000;
         T_WDG_SLOW: return 32'h5002_E000;
         T_WDG_SEC:  return 32'h5008_1000;
         T_RAMGUARD: return 32'h5008_3000;
         T_WDG_NS:   return 32'h4008_1000;
         T_SYSINFO:  return 32'h4002_0000;
         default:    return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit tgt_secure_only(int idx);
      return (idx == T_CTL_SEC) || (idx == T_SYSCTL) || (idx == T_WDG_SLOW) ||
             (idx == T_WDG_SEC) || (idx == T_RAMGUARD);
   endfunction

   function automatic logic [NUM_TGT-1:0] secure_mask();
      logic [NUM_TGT-1:0] m;
      for (int i = 0; i < NUM_TGT; i++) m[i] = tgt_secure_only(i);
      return m;
   endfunction

endpackage

// File: rtl/sna_window_fold.sv
module sna_window_fold #(
   parameter int              ADDR_W     = 32,
   parameter int              WIN_BITS   = 4,
   parameter logic [15:0]     ALIAS_MASK = 16'h002A
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] fold_o
);
   localparam int WIN_LSB  = ADDR_W - WIN_BITS;
   localparam int NUM_WIN  = 1 << WIN_BITS;

   if (WIN_BITS < 1 || WIN_BITS > 4) begin : g_bad_win
      $error("WIN_BITS must lie in 1..4");
   end

   logic [WIN_BITS-1:0] win;
   assign win = addr_i[ADDR_W-1:WIN_LSB];

   always_comb begin
      fold_o = addr_i;
      if (ALIAS_MASK[win]) fold_o[WIN_LSB] = 1'b0;
   end

   // Folded address never lands in a mirror window (R3, R4, R5)
   always_comb begin
      if (!$isunknown(addr_i))
         p_fold_leaves_mirror_r3: assert (!ALIAS_MASK[fold_o[ADDR_W-1:WIN_LSB]] || (NUM_WIN == 0));
   end
endmodule

// File: rtl/sna_region_match.sv
module sna_region_match #(
   parameter int              ADDR_W = 32,
   parameter logic [31:0]     BASE   = 32'h0,
   parameter int              SPAN   = 4096
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] offset_o
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(SPAN - 1);

   if ((SPAN & (SPAN - 1)) != 0 || SPAN < 4) begin : g_bad_span
      $error("SPAN must be a power of two of at least 4");
   end
   if ((BASE & 32'(SPAN - 1)) != 0) begin : g_bad_base
      $error("BASE must be aligned to SPAN");
   end

   assign hit_o    = ((addr_i & ~LOW_MASK) == BASE[ADDR_W-1:0]);
   assign offset_o = addr_i & LOW_MASK;
endmodule

// File: rtl/sna_target_arbiter.sv
module sna_target_arbiter #(
   parameter int                  ADDR_W  = 32,
   parameter int                  NUM_T   = 14,
   parameter logic [NUM_T-1:0]    SEC_MSK = '0
) (
   input  logic                           valid_i,
   input  logic [NUM_T-1:0]               hit_i,
   input  logic [NUM_T-1:0][ADDR_W-1:0]   off_i,
   output logic [NUM_T-1:0]               sel_o,
   output logic [ADDR_W-1:0]              offset_o,
   output logic                           miss_o
);
   localparam int          DEF_IDX = NUM_T - 1;
   localparam logic [NUM_T-1:0] DEF_ONEHOT = NUM_T'(1) << DEF_IDX;

   logic [NUM_T-1:0] sec_hits, dev_hits;

   assign sec_hits = hit_i & SEC_MSK;
   assign dev_hits = hit_i & ~SEC_MSK & ~DEF_ONEHOT;

   always_comb begin
      if (!valid_i)          sel_o = '0;
      else if (|sec_hits)    sel_o = sec_hits;
      else if (|dev_hits)    sel_o = dev_hits;
      else                   sel_o = DEF_ONEHOT;
   end

   always_comb begin
      offset_o = '0;
      for (int i = 0; i < NUM_T; i++)
         if (sel_o[i]) offset_o = offset_o | off_i[i];
   end

   assign miss_o = ~|sel_o;

   always_comb begin
      if (!$isunknown({valid_i, hit_i})) begin
         if (valid_i)
            p_sel_onehot_r1: assert ($onehot(sel_o));
         p_miss_tracks_valid_r2: assert (miss_o == !valid_i);
      end
   end
endmodule

// File: rtl/sna_alias_decoder.sv
module sna_alias_decoder
   import sna_dec_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          WIN_BITS   = 4,
   parameter logic [15:0] ALIAS_MASK = 16'h002A,
   parameter int          RAM_BYTES  = 32768,
   parameter int          SLOT_BYTES = 4096
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               valid_i,
   output logic [NUM_TGT-1:0] sel_o,
   output logic [ADDR_W-1:0]  offset_o,
   output logic               miss_o
);
   localparam logic [NUM_TGT-1:0] SEC_MSK = secure_mask();
   localparam int WIN_LSB = ADDR_W - WIN_BITS;

   if (ADDR_W != 32) begin : g_bad_aw
      $error("ADDR_W must be 32 for this memory map");
   end

   logic [ADDR_W-1:0]               fold;
   logic [NUM_TGT-1:0]              hit;
   logic [NUM_TGT-1:0][ADDR_W-1:0]  off;

   sna_window_fold #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .ALIAS_MASK(ALIAS_MASK)
   ) u_fold (
      .addr_i(addr_i),
      .fold_o(fold)
   );

   for (genvar t = 0; t < NUM_TGT - 1; t++) begin : g_tgt
      localparam int SPAN = (t == T_RAM) ? RAM_BYTES : SLOT_BYTES;
      logic [ADDR_W-1:0] cmp;
      if (tgt_secure_only(t)) begin : g_raw
         assign cmp = addr_i;
      end else begin : g_folded
         assign cmp = fold;
      end
      sna_region_match #(
         .ADDR_W(ADDR_W), .BASE(tgt_base(t)), .SPAN(SPAN)
      ) u_match (
         .addr_i  (cmp),
         .hit_o   (hit[t]),
         .offset_o(off[t])
      );
   end

   assign hit[EXP_IDX] = 1'b1;
   assign off[EXP_IDX] = fold;

   sna_target_arbiter #(
      .ADDR_W(ADDR_W), .NUM_T(NUM_TGT), .SEC_MSK(SEC_MSK)
   ) u_arb (
      .valid_i (valid_i),
      .hit_i   (hit),
      .off_i   (off),
      .sel_o   (sel_o),
      .offset_o(offset_o),
      .miss_o  (miss_o)
   );

   always_comb begin
      if (!$isunknown({addr_i, valid_i})) begin
         if (!valid_i)
            p_idle_offset_zero_r2: assert (offset_o == '0);
         if (sel_o[EXP_IDX])
            p_exp_offset_folded_r10: assert (offset_o == fold);
         if (|(sel_o & SEC_MSK))
            p_secure_only_window_r9: assert (addr_i[ADDR_W-1:WIN_LSB] == WIN_BITS'(5));
         if (sel_o[T_RAM])
            p_ram_offset_span_r6: assert (offset_o < ADDR_W'(RAM_BYTES));
         if (|(sel_o & ~(NUM_TGT'(1) << T_RAM) & ~(NUM_TGT'(1) << EXP_IDX)))
            p_slot_offset_span_r7: assert (offset_o < ADDR_W'(SLOT_BYTES));
      end
   end
endmodule

// File: tb/tb_sna_alias_decoder.sv
module tb_sna_alias_decoder;
   logic        clk = 1'b0;
   logic [31:0] addr_i = '0;
   logic        valid_i = 1'b0;
   logic [13:0] sel_o;
   logic [31:0] offset_o;
   logic        miss_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sna_alias_decoder dut (
      .addr_i(addr_i), .valid_i(valid_i),
      .sel_o(sel_o), .offset_o(offset_o), .miss_o(miss_o)
   );

   function automatic void model(input logic [31:0] a, output int idx, output logic [31:0] off);
      logic [3:0]  w;
      logic [31:0] f, pg;
      w  = a[31:28];
      f  = (w == 4'd1 || w == 4'd3 || w == 4'd5) ? (a & ~32'h1000_0000) : a;
      pg = a & 32'hFFFF_F000;
      idx = -1;
      if (w == 4'd5) begin
         case (pg)
            32'h5002_1000: idx = 7;
            32'h5002_E000: idx = 8;
            32'h5008_0000: idx = 5;
            32'h5008_1000: idx = 9;
            32'h5008_3000: idx = 10;
            default:       idx = -1;
         endcase
         if (idx >= 0) begin off = a - pg; return; end
      end
      pg = f & 32'hFFFF_F000;
      if (f >= 32'h2000_0000 && f < 32'h2000_8000) begin idx = 0; off = f - 32'h2000_0000; return; end
      case (pg)
         32'h4000_0000: idx = 1;
         32'h4000_1000: idx = 2;
         32'h4000_2000: idx = 3;
         32'h4002_F000: idx = 4;
         32'h4008_0000: idx = 6;
         32'h4008_1000: idx = 11;
         32'h4002_0000: idx = 12;
         default:       idx = 13;
      endcase
      off = (idx == 13) ? f : f - pg;
   endfunction

   function automatic string req_of(input logic [31:0] a, input int idx);
      case (idx)
         0: return "R6";
         1, 2, 3, 4: return "R7";
         5, 6: return "R8";
         7, 8, 9, 10, 11, 12: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic probe(input logic [31:0] a, input logic v);
      int idx;
      logic [31:0] eoff;
      logic [13:0] esel;
      string rq;
      @(negedge clk);
      addr_i  = a;
      valid_i = v;
      #1;
      if (!v) begin
         checks++;
         if (sel_o !== '0 || offset_o !== '0 || miss_o !== 1'b1) begin
            errors++;
            $display("FAIL R2 idle addr=%h sel=%h off=%h miss=%b exp sel=0 off=0 miss=1",
                     a, sel_o, offset_o, miss_o);
         end
         return;
      end
      model(a, idx, eoff);
      esel = 14'(1) << idx;
      rq = req_of(a, idx);
      if (a[31:28] == 4'd1) rq = {rq, "/R3"};
      if (a[31:28] == 4'd3) rq = {rq, "/R4"};
      if (a[31:28] == 4'd5) rq = {rq, "/R5"};
      checks++;
      if (sel_o !== esel || offset_o !== eoff || miss_o !== 1'b0) begin
         errors++;
         $display("FAIL %s R1 addr=%h sel=%h off=%h miss=%b exp sel=%h off=%h miss=0",
                  rq, a, sel_o, offset_o, miss_o, esel, eoff);
      end
   endtask

   localparam int NOFF = 24;
   localparam logic [27:0] OFFS [NOFF] = '{
      28'h000_0000, 28'h000_0004, 28'h000_0FFC, 28'h000_1000, 28'h000_1FFC,
      28'h000_2000, 28'h000_2FFC, 28'h000_3000, 28'h000_7FFC, 28'h000_8000,
      28'h002_0000, 28'h002_1000, 28'h002_1FFC, 28'h002_E000, 28'h002_F000,
      28'h002_FFFC, 28'h008_0000, 28'h008_0FFC, 28'h008_1000, 28'h008_2000,
      28'h008_3000, 28'h008_3FFC, 28'h008_4000, 28'hFFF_FFFC };

   initial begin
      #1;
      // R2: reset-state / idle outputs
      checks++;
      if (sel_o !== '0 || miss_o !== 1'b1) begin
         errors++;
         $display("FAIL R2 initial sel=%h miss=%b exp sel=0 miss=1", sel_o, miss_o);
      end
      // R1/R3..R10: sweep every window against boundary offsets
      for (int w = 0; w < 16; w++)
         for (int k = 0; k < NOFF; k++)
            probe({w[3:0], OFFS[k]}, 1'b1);
      // R2: strobe low on addresses that would hit devices
      probe(32'h2000_0010, 1'b0);
      probe(32'h5008_1000, 1'b0);
      probe(32'hFFFF_FFFF, 1'b0);
      // R4, R6: explicit example points
      probe(32'h3000_0010, 1'b1);
      probe(32'h2000_7FFF, 1'b1);
      probe(32'h2000_8000, 1'b1);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule